// File: doc/BRIEF.md
# Oversampled Serial Receiver with Latched Status

This block receives asynchronous serial frames on a single line. The line is sampled on an oversample tick, which the surrounding logic supplies at a fixed multiple of the bit rate. The receiver looks for a falling edge and confirms the start bit at mid-bit. It then takes a majority vote over three samples around the middle of every bit and shifts the data bits in, least significant first. When the stop bit has been voted, the finished word is handed to a holding data register.

The holding register has a set of status flags: data available, overrun, noise, parity mismatch and bad stop bit. The three error flags describe the word in the holding register, so they change only when a word is handed over. A frame that completes while the previous word is still unread is dropped and only marks an overrun. The processor reads status and data through a small read port. A status read followed by a data read clears all flags. An interrupt follows the data-available flag when it is enabled.

Frame length is set by a mode input: eight or nine data positions. When parity is enabled, the last data position carries the parity bit, checked as even or odd.

Top module: `uart_rx_top`

## Requirements
- R1: A start bit is accepted only when the voted mid-bit value is still low. Otherwise the receiver drops the attempt and hunts for a new falling edge, and it reports nothing.
- R2: Each bit value is the majority of the samples at oversample counts MID-1, MID and MID+1 (MID = OVERSAMPLE/2). If those three samples disagree in any bit of a frame, that frame's noise flag is set.
- R3: With nineBitMode = 0 the frame has 8 data positions, and with nineBitMode = 1 it has 9. Bits arrive LSB first. The word sits right-aligned in the data register, with bit 8 zero in 8-position mode.
- R4: With parityEn = 1, the XOR of all data positions, parity bit included, must equal parityOdd (0 = even, 1 = odd). A mismatch sets the parity flag.
- R5: A stop bit voted as 0 sets the framing flag. A stop bit voted as 1 is accepted with no framing error.
- R6: When the stop bit is voted and the data flag is clear, the word moves to the data register. The data flag is set in the same cycle, and the noise, parity and framing flags take that frame's values.
- R7: When a frame completes while the data flag is set, the overrun flag is set. The data register and the noise, parity and framing flags keep their values, and the new word is lost.
- R8: rxIrq is high exactly when rxIntEn is high and the data flag is set.
- R9: A read with rdAddr = 0 returns status: bit 0 data, bit 1 overrun, bit 2 noise, bit 3 parity, bit 4 framing, and all other bits zero. A read with rdAddr = 1 returns the data register.
- R10: A status read arms the clear. The next data read returns the data and clears all five flags. A data read that is not armed clears nothing.
- R11: After reset all flags, the data register and rxIrq are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| sampleTick | input | 1 | Oversample enable, OVERSAMPLE ticks per bit |
| rxLine | input | 1 | Serial input, idle high |
| nineBitMode | input | 1 | 1 selects 9 data positions, 0 selects 8 |
| parityEn | input | 1 | Treat the last data position as parity |
| parityOdd | input | 1 | 1 selects odd parity, 0 selects even |
| rxIntEn | input | 1 | Receive interrupt enable |
| rdStrobe | input | 1 | Register read, one cycle |
| rdAddr | input | 1 | 0 selects status, 1 selects data |
| rdData | output | 9 | Read data, combinational from rdAddr |
| rxIrq | output | 1 | Receive interrupt |

## Verification
The bench uses the default OVERSAMPLE of 16 and DATA_W of 9, with sampleTick held high, so every bit lasts exactly sixteen clocks. Because of this fixed bit length, a one-clock glitch lands on exactly one of the three voting samples. That makes it possible to check noise detection without corrupting data, and to place a stop bit or a short false start at a known count. The nine-position width covers both frame lengths, parity in either position, and overrun and clear races at frame boundaries.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;

  // Control-to-datapath strobes, valid for one clock.
  typedef struct packed {
    logic startFrame;
    logic shiftEn;
    logic bitVal;
    logic noiseHit;
    logic frameDone;
    logic stopBit;
  } rx_strobe_t;

  typedef enum logic [1:0] {
    RX_HUNT,
    RX_START,
    RX_DATA,
    RX_STOP
  } rx_state_e;

  localparam int STAT_FULL  = 0;
  localparam int STAT_OVR   = 1;
  localparam int STAT_NOISE = 2;
  localparam int STAT_PAR   = 3;
  localparam int STAT_FRM   = 4;

endpackage

// File: rtl/uart_rx_ctrl.sv
module uart_rx_ctrl
  import uart_rx_pkg::*;
#(
  parameter int OVERSAMPLE = 16,
  parameter int DATA_W     = 9
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       sampleTick,
  input  logic       rxLine,
  input  logic       nineBitMode,
  output rx_strobe_t strobe
);

  localparam int CNT_W = $clog2(OVERSAMPLE);
  localparam int MID   = OVERSAMPLE / 2;
  localparam int IDX_W = $clog2(DATA_W + 1);

  localparam logic [CNT_W-1:0] CNT_A    = CNT_W'(MID - 1);
  localparam logic [CNT_W-1:0] CNT_B    = CNT_W'(MID);
  localparam logic [CNT_W-1:0] CNT_DEC  = CNT_W'(MID + 1);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(OVERSAMPLE - 1);

  logic [1:0]       syncQ;
  logic             rxS;
  rx_state_e        state;
  logic [CNT_W-1:0] tickCnt;
  logic [IDX_W-1:0] bitIdx;
  logic [IDX_W-1:0] lastIdx;
  logic             sampA, sampB;
  logic             voted, disagree, decide;

  // two-flop synchronizer, line idles high
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) syncQ <= 2'b11;
    else       syncQ <= {syncQ[0], rxLine};
  end
  assign rxS = syncQ[1];

  assign lastIdx  = nineBitMode ? IDX_W'(DATA_W - 1) : IDX_W'(DATA_W - 2);
  assign voted    = (sampA & sampB) | (sampA & rxS) | (sampB & rxS);
  assign disagree = !((sampA == sampB) && (sampB == rxS));
  assign decide   = sampleTick && (state != RX_HUNT) && (tickCnt == CNT_DEC);

  always_comb begin
    strobe            = '0;
    strobe.startFrame = sampleTick && (state == RX_HUNT) && !rxS;
    strobe.shiftEn    = decide && (state == RX_DATA);
    strobe.bitVal     = voted;
    strobe.noiseHit   = decide && disagree;
    strobe.frameDone  = decide && (state == RX_STOP);
    strobe.stopBit    = voted;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= RX_HUNT;
      tickCnt <= '0;
      bitIdx  <= '0;
      sampA   <= 1'b1;
      sampB   <= 1'b1;
    end else if (sampleTick) begin
      if (state == RX_HUNT) begin
        if (!rxS) begin
          state   <= RX_START;
          tickCnt <= '0;
          bitIdx  <= '0;
        end
      end else begin
        tickCnt <= tickCnt + 1'b1;
        if (tickCnt == CNT_A) sampA <= rxS;
        if (tickCnt == CNT_B) sampB <= rxS;
        if (tickCnt == CNT_DEC) begin
          if (state == RX_START && voted) state <= RX_HUNT;
          if (state == RX_STOP)           state <= RX_HUNT;
        end
        if (tickCnt == CNT_LAST) begin
          tickCnt <= '0;
          if (state == RX_START) begin
            state  <= RX_DATA;
            bitIdx <= '0;
          end else if (state == RX_DATA) begin
            if (bitIdx == lastIdx) state <= RX_STOP;
            else                   bitIdx <= bitIdx + 1'b1;
          end
        end
      end
    end
  end

  // R1: a start bit voted high at mid-bit sends the receiver back to hunting
  assert_false_start_R1: assert property (@(posedge clk) disable iff (!rstN)
    (decide && state == RX_START && voted) |=> (state == RX_HUNT));

  // strobes that start, advance and end a frame never coincide
  assert_strobe_excl_R6: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobe.startFrame, strobe.shiftEn, strobe.frameDone}));

endmodule

// File: rtl/uart_rx_datapath.sv
module uart_rx_datapath
  import uart_rx_pkg::*;
#(
  parameter int DATA_W = 9
) (
  input  logic              clk,
  input  logic              rstN,
  input  rx_strobe_t        strobe,
  input  logic              nineBitMode,
  input  logic              parityEn,
  input  logic              parityOdd,
  input  logic              rdStrobe,
  input  logic              rdAddr,
  output logic [DATA_W-1:0] rdData,
  output logic              fullFlag
);

  logic [DATA_W-1:0] shifter;
  logic [DATA_W-1:0] word;
  logic [DATA_W-1:0] holdReg;
  logic              parAcc, noiseAcc;
  logic              fullQ, ovrQ, noiseQ, parQ, frmQ, armedQ;
  logic              clearNow, fullEff;
  logic              frameNoise, frameParErr;
  logic [DATA_W-1:0] statusVec;

  // frame shifter: bits enter at the top, so a short frame sits one place high
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shifter  <= '0;
      parAcc   <= 1'b0;
      noiseAcc <= 1'b0;
    end else if (strobe.startFrame) begin
      shifter  <= '0;
      parAcc   <= 1'b0;
      noiseAcc <= 1'b0;
    end else begin
      if (strobe.shiftEn) begin
        shifter <= {strobe.bitVal, shifter[DATA_W-1:1]};
        parAcc  <= parAcc ^ strobe.bitVal;
      end
      if (strobe.noiseHit) noiseAcc <= 1'b1;
    end
  end

  assign word        = nineBitMode ? shifter : {1'b0, shifter[DATA_W-1:1]};
  assign frameNoise  = noiseAcc | strobe.noiseHit;
  assign frameParErr = parityEn & (parAcc ^ parityOdd);
  assign clearNow    = rdStrobe & rdAddr & armedQ;
  assign fullEff     = fullQ & ~clearNow;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      holdReg <= '0;
      fullQ   <= 1'b0;
      ovrQ    <= 1'b0;
      noiseQ  <= 1'b0;
      parQ    <= 1'b0;
      frmQ    <= 1'b0;
      armedQ  <= 1'b0;
    end else begin
      if (rdStrobe) armedQ <= ~rdAddr;
      if (clearNow) begin
        fullQ  <= 1'b0;
        ovrQ   <= 1'b0;
        noiseQ <= 1'b0;
        parQ   <= 1'b0;
        frmQ   <= 1'b0;
      end
      if (strobe.frameDone) begin
        if (fullEff) begin
          ovrQ <= 1'b1;
        end else begin
          holdReg <= word;
          fullQ   <= 1'b1;
          noiseQ  <= frameNoise;
          parQ    <= frameParErr;
          frmQ    <= ~strobe.stopBit;
        end
      end
    end
  end

  always_comb begin
    statusVec             = '0;
    statusVec[STAT_FULL]  = fullQ;
    statusVec[STAT_OVR]   = ovrQ;
    statusVec[STAT_NOISE] = noiseQ;
    statusVec[STAT_PAR]   = parQ;
    statusVec[STAT_FRM]   = frmQ;
  end

  assign rdData   = rdAddr ? holdReg : statusVec;
  assign fullFlag = fullQ;

  // R6: a handoff into an empty holding register loads the word and marks it
  assert_load_word_R6: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.frameDone && !fullEff) |=> (fullQ && holdReg == $past(word)));

  // R7: an overrun keeps the held word and its error flags
  assert_overrun_keeps_R7: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.frameDone && fullEff) |=> (ovrQ && $stable(holdReg) && $stable(noiseQ)
                                       && $stable(parQ) && $stable(frmQ)));

  // R10: an armed data read with no frame ending leaves all flags clear
  assert_clear_seq_R10: assert property (@(posedge clk) disable iff (!rstN)
    (clearNow && !strobe.frameDone) |=> (!fullQ && !ovrQ && !noiseQ && !parQ && !frmQ));

endmodule

// File: rtl/uart_rx_top.sv
module uart_rx_top
  import uart_rx_pkg::*;
#(
  parameter int OVERSAMPLE = 16,
  parameter int DATA_W     = 9
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sampleTick,
  input  logic              rxLine,
  input  logic              nineBitMode,
  input  logic              parityEn,
  input  logic              parityOdd,
  input  logic              rxIntEn,
  input  logic              rdStrobe,
  input  logic              rdAddr,
  output logic [DATA_W-1:0] rdData,
  output logic              rxIrq
);

  rx_strobe_t strobe;
  logic       fullFlag;

  uart_rx_ctrl #(.OVERSAMPLE(OVERSAMPLE), .DATA_W(DATA_W)) ctrl_i (
    .clk(clk), .rstN(rstN), .sampleTick(sampleTick), .rxLine(rxLine),
    .nineBitMode(nineBitMode), .strobe(strobe)
  );

  uart_rx_datapath #(.DATA_W(DATA_W)) dp_i (
    .clk(clk), .rstN(rstN), .strobe(strobe), .nineBitMode(nineBitMode),
    .parityEn(parityEn), .parityOdd(parityOdd), .rdStrobe(rdStrobe),
    .rdAddr(rdAddr), .rdData(rdData), .fullFlag(fullFlag)
  );

  assign rxIrq = rxIntEn & fullFlag;

  // R8: the interrupt cannot rise while it is disabled
  assert_irq_mask_R8: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rxIrq) |-> rxIntEn);

endmodule

// File: tb/uart_rx_top_tb_top.sv
module uart_rx_top_tb_top;

  localparam int BITC = 16;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       sampleTick = 1'b1;
  logic       rxLine = 1'b1;
  logic       nineBitMode = 1'b0;
  logic       parityEn = 1'b0;
  logic       parityOdd = 1'b0;
  logic       rxIntEn = 1'b0;
  logic       rdStrobe = 1'b0;
  logic       rdAddr = 1'b0;
  logic [8:0] rdData;
  logic       rxIrq;

  int  nCmp = 0;
  int  nBad = 0;
  bit  done = 0;

  typedef struct {
    logic [8:0] st;
    logic [8:0] dat;
    string      tag;
  } exp_t;
  exp_t expQ[$];

  always #2.5 clk = ~clk;

  uart_rx_top dut_i (
    .clk(clk), .rstN(rstN), .sampleTick(sampleTick), .rxLine(rxLine),
    .nineBitMode(nineBitMode), .parityEn(parityEn), .parityOdd(parityOdd),
    .rxIntEn(rxIntEn), .rdStrobe(rdStrobe), .rdAddr(rdAddr),
    .rdData(rdData), .rxIrq(rxIrq)
  );

  task automatic check(input string tag, input logic [8:0] act, input logic [8:0] expv);
    nCmp++;
    if (act !== expv) begin
      nBad++;
      $display("FAIL %s: actual %h expected %h", tag, act, expv);
    end
  endtask

  task automatic readReg(input logic a, output logic [8:0] v);
    @(negedge clk);
    rdAddr = a;
    rdStrobe = 1'b1;
    #1 v = rdData;
    @(negedge clk);
    rdStrobe = 1'b0;
  endtask

  // driver: glitchPos counts start = 0, data 1..n, stop n+1
  task automatic sendFrame(input logic [8:0] w, input logic stopVal, input int glitchPos);
    int n = nineBitMode ? 9 : 8;
    for (int p = 0; p <= n + 1; p++) begin
      logic v = (p == 0) ? 1'b0 : (p <= n) ? w[p-1] : stopVal;
      for (int c = 0; c < BITC; c++) begin
        rxLine = (p == glitchPos && c == 8) ? ~v : v;
        @(negedge clk);
      end
    end
    rxLine = 1'b1;
    repeat (30) @(negedge clk);
  endtask

  task automatic expectItem(input logic [8:0] st, input logic [8:0] dat, input string tag);
    exp_t e;
    e.st = st; e.dat = dat; e.tag = tag;
    expQ.push_back(e);
  endtask

  // monitor: pop one expected word, compare, then confirm the clear
  task automatic checkNext();
    exp_t e;
    logic [8:0] v;
    e = expQ.pop_front();
    readReg(1'b0, v); check({e.tag, " status R9"}, v, e.st);
    readReg(1'b1, v); check({e.tag, " data R9"}, v, e.dat);
    readReg(1'b0, v); check({e.tag, " cleared R10"}, v, 9'h000);
    readReg(1'b1, v);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      nBad++; nCmp++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
      $finish;
    end
  end

  initial begin
    logic [8:0] v;
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    repeat (4) @(negedge clk);

    // R11 reset state
    check("R11 irq", {8'h0, rxIrq}, 9'h0);
    readReg(1'b0, v); check("R11 status", v, 9'h000);
    readReg(1'b1, v); check("R11 data", v, 9'h000);

    // R6, R8 basic 8-position frame with interrupt enabled
    rxIntEn = 1'b1;
    sendFrame(9'h0A5, 1'b1, -1);
    expectItem(9'h001, 9'h0A5, "R6 basic");
    check("R8 irq set", {8'h0, rxIrq}, 9'h1);
    checkNext();
    check("R8 irq clear", {8'h0, rxIrq}, 9'h0);

    // R3 nine positions
    nineBitMode = 1'b1;
    sendFrame(9'h1C3, 1'b1, -1);
    expectItem(9'h001, 9'h1C3, "R3 nine");
    checkNext();

    // R4 parity variants
    nineBitMode = 1'b0; parityEn = 1'b1; parityOdd = 1'b0;
    sendFrame(9'h0B1, 1'b1, -1);
    expectItem(9'h001, 9'h0B1, "R4 even ok");
    checkNext();
    parityOdd = 1'b1;
    sendFrame(9'h0B1, 1'b1, -1);
    expectItem(9'h009, 9'h0B1, "R4 odd bad");
    checkNext();
    nineBitMode = 1'b1;
    sendFrame(9'h1FF, 1'b1, -1);
    expectItem(9'h001, 9'h1FF, "R4 nine odd ok");
    checkNext();
    sendFrame(9'h0FF, 1'b1, -1);
    expectItem(9'h009, 9'h0FF, "R4 nine odd bad");
    checkNext();
    nineBitMode = 1'b0; parityEn = 1'b0; parityOdd = 1'b0;

    // R2 noise on a data bit and on the start bit, data intact
    sendFrame(9'h000, 1'b1, 4);
    expectItem(9'h005, 9'h000, "R2 data glitch");
    checkNext();
    sendFrame(9'h0C3, 1'b1, 0);
    expectItem(9'h005, 9'h0C3, "R2 start glitch");
    checkNext();

    // R5 low stop bit; the trailing low also tests R1 rejection
    sendFrame(9'h05A, 1'b0, -1);
    expectItem(9'h011, 9'h05A, "R5 framing");
    checkNext();

    // R1 short low pulse is not a start bit
    rxLine = 1'b0;
    repeat (6) @(negedge clk);
    rxLine = 1'b1;
    repeat (40) @(negedge clk);
    readReg(1'b0, v); check("R1 no frame", v, 9'h000);
    readReg(1'b1, v); check("R1 data kept", v, 9'h05A);
    sendFrame(9'h066, 1'b1, -1);
    expectItem(9'h001, 9'h066, "R1 recovers");
    checkNext();

    // R7 overrun, the lost frame also carries noise
    sendFrame(9'h011, 1'b1, -1);
    sendFrame(9'h022, 1'b1, 3);
    expectItem(9'h003, 9'h011, "R7 overrun");
    checkNext();

    // R10 unarmed data read clears nothing
    sendFrame(9'h033, 1'b1, -1);
    readReg(1'b1, v); check("R10 unarmed data", v, 9'h033);
    readReg(1'b0, v); check("R10 still full", v, 9'h001);
    readReg(1'b1, v); check("R10 armed data", v, 9'h033);
    readReg(1'b0, v); check("R10 cleared", v, 9'h000);
    readReg(1'b1, v);

    // R8 masked interrupt
    rxIntEn = 1'b0;
    sendFrame(9'h044, 1'b1, -1);
    check("R8 masked", {8'h0, rxIrq}, 9'h0);
    expectItem(9'h001, 9'h044, "R8 masked frame");
    checkNext();

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
    $finish;
  end

endmodule